// File: doc/BRIEF.md
# Eye-Centre Sampling Phase Selector

This block serves one serial receive lane. Eight sampling phases sit 45 degrees apart across each unit interval (UI). On every UI the block takes one 8-bit vector with one sample per phase. It counts where data edges fall between neighbouring phases over a training window. It then chooses the phase opposite the busiest edge position, which is the centre of the data eye, so the sampling error stays within 1/8 UI.

The recovered bit comes from the chosen phase. It is presented with a valid strobe and with a write strobe for the downstream synchroniser buffer. The block has three operating modes:
- A manual mode takes the phase straight from an input.
- A lock-once mode trains once and then holds its phase.
- A tracking mode keeps retraining and moves its phase by at most one step per window.

Top module: `eye_phase_sel`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `locked` is 0 in the lock-once and tracking modes, `phase_sel` is 0, and `rx_valid` and `wr_en` are 0.
- R2: On each UI with `ui_valid` high, edge position i (0..6) registers an edge when `samples[i]` differs from `samples[i+1]`. Position 7 registers an edge when `samples[0]` differs from `samples[7]` of the previous valid UI, which is taken as 0 after reset.
- R3: A window is WINDOW_LEN valid UIs. The UI that completes the window is counted before the decision is made. At that point the peak is the position with the largest count, and the lowest index wins a tie. The target phase is (peak + 4) mod 8. All counts then restart from zero, and `locked` never rises except at a window end.
- R4: `mode` = 1 (lock-once): at the first window end after reset or retrain, `phase_sel` takes the target and `locked` rises. After that the phase does not change while the lock holds.
- R5: A one-cycle `retrain` pulse drops `locked` and clears the counts and the window position. `phase_sel` keeps its value until the next lock.
- R6: `mode` = 2 (tracking): the first window end sets the target directly and raises `locked`. Each later window end moves the phase one step toward the target by the shorter way round. When the target lies four steps away the phase moves up by one, and when the target equals the current phase it does not move.
- R7: `mode` = 0 (manual): `phase_sel` equals `manual_phase` and `locked` is 1, immediately and at all times.
- R8: One cycle after a clock edge with `ui_valid` high, `rx_valid` is 1 and `rx_bit` equals `samples[phase_sel]` as seen at that edge. After an edge with `ui_valid` low, `rx_valid` is 0.
- R9: `wr_en` is 1 one cycle after an edge where `ui_valid` and `locked` are both high, and 0 otherwise.
- R10: `mode` code 3 behaves exactly like lock-once.
- R11: Each edge count saturates at 2^CNT_W - 1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ui_valid | input | 1 | A new per-UI sample vector is present |
| samples | input | 8 | One sample per phase, bit i from phase i |
| mode | input | 2 | 0 manual, 1 lock-once, 2 tracking, 3 as lock-once |
| manual_phase | input | 3 | Phase used in manual mode |
| retrain | input | 1 | Pulse that restarts training |
| rx_bit | output | 1 | Recovered data bit |
| rx_valid | output | 1 | Recovered bit is new this cycle |
| wr_en | output | 1 | Write strobe to the downstream buffer |
| phase_sel | output | 3 | Phase index in use |
| locked | output | 1 | Phase choice is established |

## Verification
The assertions on phase movement assume that `mode` holds steady between resets. They make allowance for a changed mode, but a mid-run mode change is not a case they aim to cover, and the stimulus only changes `mode` while `rst` is high. `retrain` is driven as a single-cycle pulse on a cycle without `ui_valid`. Sample vectors are built so that the edge counts are known exactly: a single edge position per pattern in the phase sweep, and two competing positions in the saturation case. The manual-mode and recovered-bit checks use arbitrary vectors, since no count matters there.

// File: rtl/eps_pkg.sv
package eps_pkg;
    localparam int NPH  = 8;
    localparam int PH_W = 3;

    typedef logic [PH_W-1:0] phase_t;
    typedef logic [NPH-1:0]  phvec_t;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'd0,
        MODE_ONCE   = 2'd1,
        MODE_TRACK  = 2'd2,
        MODE_SPARE  = 2'd3
    } align_mode_e;

    typedef struct packed {
        logic   done;
        phase_t peak;
    } win_result_t;

    // Phase lying half a UI away from the given edge position.
    function automatic phase_t eye_centre(phase_t edge_pos);
        return edge_pos + phase_t'(NPH / 2);
    endfunction

    // Single step toward tgt along the shorter arc; ties go upward.
    function automatic phase_t step_toward(phase_t cur, phase_t tgt);
        phase_t d;
        d = tgt - cur;
        if (d == '0)
            return cur;
        else if (d <= phase_t'(NPH / 2))
            return cur + phase_t'(1);
        else
            return cur - phase_t'(1);
    endfunction

    // Edge flags between neighbouring phases, last one wrapping to next UI.
    function automatic phvec_t find_edges(phvec_t s, logic prev_last);
        phvec_t e;
        for (int i = 0; i < NPH - 1; i++)
            e[i] = s[i] ^ s[i+1];
        e[NPH-1] = prev_last ^ s[0];
        return e;
    endfunction
endpackage

// File: rtl/eps_edge_detect.sv
module eps_edge_detect
    import eps_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ui_valid,
    input  phvec_t samples,
    output phvec_t edges,
    output logic   edge_valid
);
    logic prev_last_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_last_q <= 1'b0;
        else if (ui_valid)
            prev_last_q <= samples[NPH-1];
    end

    always_comb begin
        edges      = find_edges(samples, prev_last_q);
        edge_valid = ui_valid;
    end
endmodule

// File: rtl/eps_hist.sv
module eps_hist
    import eps_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WINDOW_LEN = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        edge_valid,
    input  phvec_t      edges,
    output win_result_t result
);
    localparam int WIN_W = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(WINDOW_LEN - 1);

    logic [WIN_W-1:0] win_q;
    logic             done_w;
    logic [NPH-1:0][CNT_W-1:0] cnt_all;
    logic [NPH-1:0][CNT_W-1:0] nxt_all;

    assign done_w = edge_valid && (win_q == WIN_LAST);

    generate
        for (genvar gi = 0; gi < NPH; gi++) begin : g_cnt
            logic [CNT_W-1:0] c_q;
            logic             bump;

            assign bump         = edges[gi] && (c_q != CNT_MAX);
            assign nxt_all[gi]  = c_q + CNT_W'(bump);
            assign cnt_all[gi]  = c_q;

            always_ff @(posedge clk) begin
                if (rst || clear)
                    c_q <= '0;
                else if (edge_valid)
                    c_q <= done_w ? '0 : nxt_all[gi];
            end

            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (!$past(clear) && !$past(done_w)) |-> (cnt_all[gi] >= $past(cnt_all[gi]))); // R11
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear)
            win_q <= '0;
        else if (edge_valid)
            win_q <= done_w ? '0 : win_q + WIN_W'(1);
    end

    // Largest count wins; strict compare keeps the lowest index on ties.
    always_comb begin
        logic [CNT_W-1:0] best_val;
        phase_t           best_pos;
        best_val = nxt_all[0];
        best_pos = '0;
        for (int i = 1; i < NPH; i++) begin
            if (nxt_all[i] > best_val) begin
                best_val = nxt_all[i];
                best_pos = phase_t'(i);
            end
        end
        result.done = done_w;
        result.peak = best_pos;
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (rst) (win_q <= WIN_LAST)); // R3
endmodule

// File: rtl/eps_phase_ctrl.sv
module eps_phase_ctrl
    import eps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  phase_t      manual_phase,
    input  logic        retrain,
    input  win_result_t win,
    output phase_t      phase_o,
    output logic        locked_o
);
    align_mode_e mode_e;
    phase_t      phase_q;
    phase_t      target;
    logic        lock_q;
    logic        win_done;

    assign mode_e   = align_mode_e'(mode);
    assign target   = eye_centre(win.peak);
    assign win_done = win.done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            lock_q  <= 1'b0;
        end else if (retrain) begin
            lock_q  <= 1'b0;
        end else if (win_done) begin
            case (mode_e)
                MODE_TRACK: begin
                    if (!lock_q) begin
                        phase_q <= target;
                        lock_q  <= 1'b1;
                    end else begin
                        phase_q <= step_toward(phase_q, target);
                    end
                end
                MODE_ONCE, MODE_SPARE: begin
                    if (!lock_q) begin
                        phase_q <= target;
                        lock_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (mode_e == MODE_MANUAL) begin
            phase_o  = manual_phase;
            locked_o = 1'b1;
        end else begin
            phase_o  = phase_q;
            locked_o = lock_q;
        end
    end

    AST_LOCK_AT_WINDOW: assert property (@(posedge clk) disable iff (rst) $rose(lock_q) |-> $past(win_done)); // R3
    AST_ONCE_FROZEN: assert property (@(posedge clk) disable iff (rst) (lock_q && $past(lock_q) && mode_e != MODE_TRACK && $past(mode_e) != MODE_TRACK) |-> $stable(phase_q)); // R4
    AST_TRACK_STEP: assert property (@(posedge clk) disable iff (rst) (lock_q && $past(lock_q)) |-> ((phase_t'(phase_q - $past(phase_q)) == 3'd0) || (phase_t'(phase_q - $past(phase_q)) == 3'd1) || (phase_t'(phase_q - $past(phase_q)) == 3'd7))); // R6
    AST_RETRAIN_DROP: assert property (@(posedge clk) disable iff (rst) $past(retrain) |-> (!lock_q && $stable(phase_q))); // R5
endmodule

// File: rtl/eye_phase_sel.sv
module eye_phase_sel
    import eps_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WINDOW_LEN = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ui_valid,
    input  logic [7:0] samples,
    input  logic [1:0] mode,
    input  logic [2:0] manual_phase,
    input  logic       retrain,
    output logic       rx_bit,
    output logic       rx_valid,
    output logic       wr_en,
    output logic [2:0] phase_sel,
    output logic       locked
);
    phvec_t      edges;
    logic        edge_valid;
    win_result_t win;
    phase_t      phase_w;
    logic        locked_w;

    eps_edge_detect u_edge (
        .clk        (clk),
        .rst        (rst),
        .ui_valid   (ui_valid),
        .samples    (samples),
        .edges      (edges),
        .edge_valid (edge_valid)
    );

    eps_hist #(
        .CNT_W      (CNT_W),
        .WINDOW_LEN (WINDOW_LEN)
    ) u_hist (
        .clk        (clk),
        .rst        (rst),
        .clear      (retrain),
        .edge_valid (edge_valid),
        .edges      (edges),
        .result     (win)
    );

    eps_phase_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .manual_phase (manual_phase),
        .retrain      (retrain),
        .win          (win),
        .phase_o      (phase_w),
        .locked_o     (locked_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_bit   <= 1'b0;
            rx_valid <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            rx_valid <= ui_valid;
            wr_en    <= ui_valid && locked_w;
            if (ui_valid)
                rx_bit <= samples[phase_w];
        end
    end

    assign phase_sel = phase_w;
    assign locked    = locked_w;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) ui_valid |=> rx_valid); // R8
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !ui_valid |=> !rx_valid); // R8
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) wr_en |-> rx_valid); // R9
endmodule

// File: tb/eye_phase_sel_bench.sv
module eye_phase_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WL = 16;
    localparam int CW = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ui_valid = 1'b0;
    logic [7:0] samples = '0;
    logic [1:0] mode = 2'd1;
    logic [2:0] manual_phase = '0;
    logic       retrain = 1'b0;
    logic       rx_bit, rx_valid, wr_en, locked;
    logic [2:0] phase_sel;

    int errors = 0;
    int checks = 0;

    eye_phase_sel #(.CNT_W(CW), .WINDOW_LEN(WL)) u_eye_phase_sel (
        .clk (clk), .rst (rst), .ui_valid (ui_valid), .samples (samples),
        .mode (mode), .manual_phase (manual_phase), .retrain (retrain),
        .rx_bit (rx_bit), .rx_valid (rx_valid), .wr_en (wr_en),
        .phase_sel (phase_sel), .locked (locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst  = 1'b1;
        mode = m;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // One UI: drive at a falling edge, result is visible at the next one.
    task automatic send(input logic [7:0] v);
        @(negedge clk);
        samples  = v;
        ui_valid = 1'b1;
        @(negedge clk);
        ui_valid = 1'b0;
    endtask

    // Single edge position p, alternating data per UI.
    function automatic logic [7:0] pat(input int p, input int k);
        logic [7:0] v;
        for (int i = 0; i < 8; i++)
            v[i] = (i <= p) ? logic'(k & 1) : logic'((k + 1) & 1);
        return v;
    endfunction

    task automatic window(input int p);
        for (int k = 0; k < WL; k++) send(pat(p, k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        rst = 1'b1;
        mode = 2'd1;
        repeat (3) @(negedge clk);
        chk("R1 locked", locked, 0);
        chk("R1 phase", phase_sel, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 wr_en", wr_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 locked after release", locked, 0);

        // R2 R3 R4 sweep of edge positions in lock-once mode
        for (int p = 0; p < 8; p++) begin
            do_reset(2'd1);
            send(pat(p, 0));
            chk("R9 no write before lock", wr_en, 0);
            chk("R8 valid during training", rx_valid, 1);
            for (int k = 1; k < WL - 1; k++) send(pat(p, k));
            chk("R3 not locked before window end", locked, 0);
            send(pat(p, WL - 1));
            chk("R4 locked at window end", locked, 1);
            chk("R2 R3 phase opposite edge", phase_sel, (p + 4) % 8);
            // R8 R9 recovered bit at the chosen phase
            for (int k = 0; k < 4; k++) begin
                logic [7:0] v;
                v = 8'((p * 37 + k * 91 + 13) & 255);
                send(v);
                chk("R8 rx_bit", rx_bit, v[(p + 4) % 8]);
                chk("R9 wr_en locked", wr_en, 1);
            end
            @(negedge clk);
            chk("R8 idle valid low", rx_valid, 0);
            // R4 frozen despite a new edge position
            window((p + 3) % 8);
            window((p + 3) % 8);
            chk("R4 phase frozen", phase_sel, (p + 4) % 8);
            // R5 retrain
            @(negedge clk);
            retrain = 1'b1;
            @(negedge clk);
            retrain = 1'b0;
            chk("R5 lock dropped", locked, 0);
            chk("R5 phase held", phase_sel, (p + 4) % 8);
            window((p + 3) % 8);
            chk("R5 relocked", locked, 1);
            chk("R5 new phase", phase_sel, (p + 7) % 8);
        end

        // R10 spare code behaves as lock-once
        do_reset(2'd3);
        window(1);
        chk("R10 locked", locked, 1);
        chk("R10 phase", phase_sel, 5);
        window(6);
        chk("R10 frozen", phase_sel, 5);

        // R6 tracking
        do_reset(2'd2);
        chk("R6 unlocked at start", locked, 0);
        window(0);
        chk("R6 first lock", locked, 1);
        chk("R6 first phase", phase_sel, 4);
        window(3); chk("R6 step up 1", phase_sel, 5);
        window(3); chk("R6 step up 2", phase_sel, 6);
        window(3); chk("R6 step up 3", phase_sel, 7);
        window(3); chk("R6 hold at target", phase_sel, 7);
        window(1); chk("R6 step down wrap side", phase_sel, 6);
        window(1); chk("R6 step down", phase_sel, 5);
        window(1); chk("R6 hold", phase_sel, 5);
        window(5); chk("R6 opposite goes up", phase_sel, 6);
        chk("R6 still locked", locked, 1);

        // R7 manual mode
        do_reset(2'd0);
        chk("R7 locked at once", locked, 1);
        for (int m = 0; m < 8; m++) begin
            logic [7:0] v;
            manual_phase = 3'(m);
            v = 8'((m * 53 + 29) & 255);
            send(v);
            chk("R7 phase follows input", phase_sel, m);
            chk("R7 R8 rx_bit", rx_bit, v[m]);
            chk("R9 wr_en manual", wr_en, 1);
        end
        window(2);
        chk("R7 windows ignored", phase_sel, 7);

        // R11 saturation: both counts pinned at max, lowest index wins
        do_reset(2'd1);
        for (int k = 0; k < WL - 1; k++) send(8'h38);
        send(8'hF8);
        chk("R11 saturated tie", phase_sel, 6);
        chk("R11 locked", locked, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule